// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns a parallel character into a framed asynchronous serial stream. Bytes arrive on a valid/ready handshake and enter a one-entry holding stage. A frame sequencer takes the byte from that stage, shifts it out and times each bit against a 16x baud tick that it receives from outside. The frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then the stop time at the mark (high) level. The framing settings are taken from the configuration inputs at the moment a frame is loaded. They hold for the whole frame.

Parity can be odd, even, or stuck at a constant 1 or 0. When a long stop time is selected, it is 1.5 bits for 5-bit words and 2 bits for every other length. A break input pulls the line to the space (low) level for as long as it is held. The frame timing keeps running underneath the break. A transmitter-empty flag reports when nothing is held and nothing is being shifted.

Top module: `serial_tx_framer`

## Requirements
- R1: After reset, txd is 1, tx_empty is 1 and in_ready is 1.
- R2: A frame begins with a start bit of 0. The data bits follow, least significant bit first. Each bit lasts 16 baud ticks. The word-length code word_len selects the number of data bits: 2'b00 selects 5, 2'b01 selects 6, 2'b10 selects 7 and 2'b11 selects 8. The stop level is 1.
- R3: par_cfg is {stick, even, enable}. When bit 0 is 0, no parity bit is sent. 3'b001 sends a bit that makes the count of ones in data plus parity odd. 3'b011 makes that count even. 3'b101 sends a constant 1 and 3'b111 sends a constant 0.
- R4: When stop_long is 0, the stop time is 16 ticks. When stop_long is 1, it is 24 ticks for 5-bit words and 32 ticks for every other word length. tx_empty rises on the tick that ends the stop time.
- R5: in_ready is 1 only while the holding stage is empty. A byte accepted while another frame is shifting starts its start bit within two clock cycles after the previous stop time ends.
- R6: tx_empty is 0 while a byte is held or a frame is being shifted. It is 1 otherwise. While tx_empty is 1 and brk is 0, txd is 1.
- R7: While brk is 1, txd is 0. A frame in progress keeps advancing its tick timing, so it ends on the same tick it would have ended on without the break.
- R8: After brk falls, any remaining part of a frame that the break overlapped is sent as 1. No frame is loaded while brk is 1, nor until 16 ticks have passed after brk falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| word_len | input | 2 | Data-bit count code (5 to 8) |
| stop_long | input | 1 | Selects the long stop time |
| par_cfg | input | 3 | Parity mode {stick, even, enable} |
| brk | input | 1 | Forces the line to the space level |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | in_data is offered |
| in_ready | output | 1 | Holding stage can accept a byte |
| txd | output | 1 | Serial line output |
| tx_empty | output | 1 | Nothing held and nothing shifting |

## Verification
A wrong bit counter or shift register shows up on txd within one bit time, because every bit is sampled at its midpoint. A stop-time or tick-count error moves the rise of tx_empty off its expected tick. The bench catches this at the last tick of each frame. A holding-stage fault shows at in_ready as soon as the next byte is offered, or as a late or missing start bit after a back-to-back frame. A break-handling fault shows as a 0 left on the line after release, as a frame that starts too early, or as an end tick that has shifted.

// File: rtl/txs_pkg.sv
package txs_pkg;

  localparam int unsigned TXS_DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } txs_state_e;

  typedef struct packed {
    logic [1:0] wl;
    logic       stb;
    logic [2:0] par;
  } txs_cfg_t;

  // number of data bits for a word-length code
  function automatic int unsigned data_bits(input logic [1:0] wl);
    return 32'd5 + {30'd0, wl};
  endfunction

  // parity bit for the selected mode; only the active data bits count
  function automatic logic parity_of(input logic [TXS_DW-1:0] d,
                                     input logic [1:0] wl,
                                     input logic [2:0] par);
    logic [TXS_DW-1:0] m;
    logic x;
    m = d & (8'hFF >> (2'd3 - wl));
    x = ^m;
    case (par)
      3'b001:  return ~x;
      3'b011:  return x;
      3'b101:  return 1'b1;
      3'b111:  return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // stop time in ticks
  function automatic int unsigned stop_ticks(input logic [1:0] wl,
                                             input logic stb,
                                             input int unsigned tpb);
    if (!stb) return tpb;
    if (wl == 2'b00) return tpb + tpb / 2;
    return 2 * tpb;
  endfunction

endpackage

// File: rtl/txs_hold.sv
module txs_hold
  import txs_pkg::*;
#(
  parameter int unsigned W = TXS_DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         pop,
  output logic         hold_full,
  output logic [W-1:0] hold_data
);

  logic push;

  assign in_ready = !hold_full;
  assign push     = in_valid && !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (push) begin
      hold_full <= 1'b1;
      hold_data <= in_data;
    end else if (pop) begin
      hold_full <= 1'b0;
    end
  end

  // a held byte stays put until the sequencer takes it
  assert_hold_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !pop) |=> (hold_full && $stable(hold_data)));

  // the sequencer never takes from an empty stage
  assert_pop_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> hold_full);

endmodule

// File: rtl/txs_shift.sv
module txs_shift
  import txs_pkg::*;
#(
  parameter int unsigned W     = TXS_DW,
  parameter int unsigned TPB   = 16,
  parameter int unsigned CNT_W = $clog2(2 * TPB)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         start_ok,
  input  logic         hold_full,
  input  logic [W-1:0] hold_data,
  input  txs_cfg_t     cfg,
  output logic         pop,
  output logic         busy,
  output logic         line_bit,
  output logic         frame_end
);

  txs_state_e        state;
  logic [W-1:0]      shreg;
  txs_cfg_t          cfg_q;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        bit_idx;
  logic              par_q;
  logic              bit_end;
  logic [CNT_W-1:0]  limit_m1;
  logic [2:0]        last_idx;

  assign busy = (state != ST_IDLE);
  assign pop  = (state == ST_IDLE) && hold_full && start_ok;

  always_comb begin
    if (state == ST_STOP) limit_m1 = CNT_W'(stop_ticks(cfg_q.wl, cfg_q.stb, TPB) - 1);
    else                  limit_m1 = CNT_W'(TPB - 1);
  end

  assign last_idx  = 3'(data_bits(cfg_q.wl) - 1);
  assign bit_end   = tick && busy && (cnt == limit_m1);
  assign frame_end = bit_end && (state == ST_STOP);

  always_comb begin
    case (state)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = shreg[0];
      ST_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      cfg_q   <= '0;
      cnt     <= '0;
      bit_idx <= '0;
      par_q   <= 1'b1;
    end else if (pop) begin
      state   <= ST_START;
      shreg   <= hold_data;
      cfg_q   <= cfg;
      cnt     <= '0;
      bit_idx <= '0;
      par_q   <= parity_of(hold_data, cfg.wl, cfg.par);
    end else if (tick && busy) begin
      if (!bit_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (state)
          ST_START: state <= ST_DATA;
          ST_DATA: begin
            shreg <= shreg >> 1;
            if (bit_idx == last_idx) state <= cfg_q.par[0] ? ST_PAR : ST_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end
          ST_PAR:  state <= ST_STOP;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // data index never passes the configured word length
  assert_data_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (bit_idx <= last_idx));

  // timing only moves on a tick
  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(cnt));

  // a frame returns to idle only through its stop time
  assert_end_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (state == ST_IDLE || state == ST_START));

endmodule

// File: rtl/txs_line.sv
module txs_line #(
  parameter int unsigned TPB   = 16,
  parameter int unsigned CNT_W = $clog2(2 * TPB)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic brk,
  input  logic busy,
  input  logic line_bit,
  input  logic load,
  output logic start_ok,
  output logic txd
);

  localparam int unsigned GW = $clog2(TPB + 1);

  logic [GW-1:0] guard;
  logic          masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guard  <= '0;
      masked <= 1'b0;
    end else begin
      if (brk)                      guard <= GW'(TPB);
      else if (tick && guard != '0) guard <= guard - 1'b1;

      if (load)              masked <= 1'b0;
      else if (brk && busy)  masked <= 1'b1;
    end
  end

  assign start_ok = !brk && (guard == '0);
  assign txd      = brk ? 1'b0 : (masked ? 1'b1 : line_bit);

  // release always arms a full bit of mark time
  assert_guard_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk) |-> (guard == GW'(TPB)));

  // nothing starts while the mark guard is still running
  assert_guard_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (guard != '0) |-> !load);

endmodule

// File: rtl/serial_tx_framer.sv
module serial_tx_framer
  import txs_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic [1:0]           word_len,
  input  logic                 stop_long,
  input  logic [2:0]           par_cfg,
  input  logic                 brk,
  input  logic [TXS_DW-1:0]    in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic                 txd,
  output logic                 tx_empty
);

  localparam int unsigned CNT_W = $clog2(2 * TICKS_PER_BIT);

  txs_cfg_t          cfg;
  logic              pop;
  logic              hold_full;
  logic [TXS_DW-1:0] hold_data;
  logic              busy;
  logic              line_bit;
  logic              frame_end;
  logic              start_ok;

  assign cfg = '{wl: word_len, stb: stop_long, par: par_cfg};

  txs_hold #(.W(TXS_DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .pop(pop), .hold_full(hold_full), .hold_data(hold_data)
  );

  txs_shift #(.W(TXS_DW), .TPB(TICKS_PER_BIT), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .start_ok(start_ok),
    .hold_full(hold_full), .hold_data(hold_data), .cfg(cfg), .pop(pop),
    .busy(busy), .line_bit(line_bit), .frame_end(frame_end)
  );

  txs_line #(.TPB(TICKS_PER_BIT), .CNT_W(CNT_W)) u_line (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .brk(brk), .busy(busy),
    .line_bit(line_bit), .load(pop), .start_ok(start_ok), .txd(txd)
  );

  assign tx_empty = !hold_full && !busy;

  // idle line sits at mark unless a break holds it low
  assert_empty_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !brk) |-> txd);

  // a full holding stage means the transmitter is not empty
  assert_ready_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !tx_empty);

  // a frame never starts on a cycle that saw break
  assert_no_start_brk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(brk));

  // the end of a frame is followed by an empty or reloading transmitter
  assert_end_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !hold_full) |=> tx_empty);

endmodule

// File: tb/test_serial_tx_framer.sv
module test_serial_tx_framer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [1:0] word_len = 2'b11;
  logic       stop_long = 1'b0;
  logic [2:0] par_cfg = 3'b000;
  logic       brk = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       txd;
  logic       tx_empty;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_tx_framer i_serial_tx_framer (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .word_len(word_len),
    .stop_long(stop_long), .par_cfg(par_cfg), .brk(brk), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .txd(txd), .tx_empty(tx_empty)
  );

  // data, word_len, stop_long, par_cfg
  localparam logic [13:0] VEC [8] = '{
    {8'hA5, 2'b11, 1'b0, 3'b000},
    {8'h3B, 2'b00, 1'b0, 3'b001},
    {8'h3B, 2'b01, 1'b1, 3'b011},
    {8'h96, 2'b10, 1'b0, 3'b101},
    {8'h5A, 2'b11, 1'b1, 3'b111},
    {8'h17, 2'b00, 1'b1, 3'b000},
    {8'hE1, 2'b11, 1'b0, 3'b001},
    {8'h0F, 2'b10, 1'b1, 3'b011}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) baud_tick = 1'b1;
      @(negedge clk) baud_tick = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk);
    in_data  = d;
    in_valid = 1'b1;
    @(posedge clk);
    while (!in_ready) @(posedge clk);
    @(negedge clk) in_valid = 1'b0;
  endtask

  function automatic int exp_stop(input logic [1:0] wl, input logic stb);
    if (stb == 1'b0) return 16;
    return (wl == 2'b00) ? 24 : 32;
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input int nb, input logic [2:0] p);
    int ones = 0;
    for (int i = 0; i < nb; i++) if (d[i]) ones++;
    if (p == 3'b101) return 1'b1;
    if (p == 3'b111) return 1'b0;
    if (p == 3'b011) return (ones % 2) == 1;
    return (ones % 2) == 0;
  endfunction

  // called right after the frame was loaded (no ticks yet)
  task automatic check_frame(input logic [7:0] d, input logic [1:0] wl,
                             input logic stb, input logic [2:0] p);
    int nb = 5 + int'(wl);
    int st = exp_stop(wl, stb);
    tick_n(8);
    chk(txd == 1'b0, "R2 start bit", txd, 0);
    for (int i = 0; i < nb; i++) begin
      tick_n(16);
      chk(txd == d[i], "R2 data bit", txd, d[i]);
    end
    if (p[0]) begin
      tick_n(16);
      chk(txd == exp_par(d, nb, p), "R3 parity bit", txd, exp_par(d, nb, p));
    end
    tick_n(16);
    chk(txd == 1'b1, "R2 stop level", txd, 1);
    tick_n(st - 9);
    chk(tx_empty == 1'b0, "R4 stop not yet over", tx_empty, 0);
    tick_n(1);
    chk(tx_empty == 1'b1, "R4 stop ends on tick", tx_empty, 1);
    chk(txd == 1'b1, "R6 idle mark", txd, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run finished)");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 txd reset", txd, 1);
    chk(tx_empty == 1'b1, "R1 empty reset", tx_empty, 1);
    chk(in_ready == 1'b1, "R1 ready reset", in_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk over formats
    for (int v = 0; v < 8; v++) begin
      word_len  = VEC[v][5:4];
      stop_long = VEC[v][3];
      par_cfg   = VEC[v][2:0];
      send_byte(VEC[v][13:6]);
      repeat (2) @(negedge clk);
      chk(txd == 1'b0 && tx_empty == 1'b0, "R6 frame started", txd, 0);
      check_frame(VEC[v][13:6], VEC[v][5:4], VEC[v][3], VEC[v][2:0]);
    end

    // back-to-back through the holding stage
    word_len = 2'b11; stop_long = 1'b0; par_cfg = 3'b000;
    send_byte(8'h81);
    repeat (2) @(negedge clk);
    send_byte(8'h4E);
    chk(in_ready == 1'b0, "R5 holding stage full", in_ready, 0);
    chk(tx_empty == 1'b0, "R6 held byte", tx_empty, 0);
    tick_n(159);
    chk(txd == 1'b1, "R5 first stop", txd, 1);
    tick_n(1);
    repeat (2) @(negedge clk);
    chk(txd == 1'b0, "R5 next start follows", txd, 0);
    chk(in_ready == 1'b1, "R5 stage free again", in_ready, 1);
    check_frame(8'h4E, 2'b11, 1'b0, 3'b000);

    // break over a frame in progress
    send_byte(8'h00);
    repeat (2) @(negedge clk);
    tick_n(20);
    @(negedge clk) brk = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0, "R7 break forces low", txd, 0);
    tick_n(40);
    chk(txd == 1'b0, "R7 break held", txd, 0);
    @(negedge clk) brk = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R8 masked after release", txd, 1);
    tick_n(40);
    chk(txd == 1'b1, "R8 remainder sent as mark", txd, 1);
    tick_n(59);
    chk(tx_empty == 1'b0, "R7 timing kept", tx_empty, 0);
    tick_n(1);
    chk(tx_empty == 1'b1, "R7 frame ends on time", tx_empty, 1);

    // byte offered during break waits for release plus one bit
    @(negedge clk) brk = 1'b1;
    send_byte(8'h3C);
    repeat (3) @(negedge clk);
    chk(txd == 1'b0 && tx_empty == 1'b0, "R8 held during break", tx_empty, 0);
    tick_n(20);
    chk(in_ready == 1'b0, "R8 no load in break", in_ready, 0);
    @(negedge clk) brk = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R8 line released", txd, 1);
    tick_n(15);
    chk(txd == 1'b1, "R8 guard mark", txd, 1);
    tick_n(1);
    repeat (2) @(negedge clk);
    chk(txd == 1'b0, "R8 start after guard", txd, 0);
    check_frame(8'h3C, 2'b11, 1'b0, 3'b000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule